// File: doc/BRIEF.md
# SPI Register File with Sticky Interrupts

This block is the control-plane front end of a line transceiver. A host reaches it over a four-wire SPI link in mode 0, with clock idle low and data taken on the rising SCLK edge. The link gives access to four byte-wide registers: an interrupt status register, a line-driver configuration register, an auxiliary I/O configuration register and a mode register. The configuration bits drive the analog blocks next to this one. Fault levels and event pulses from those blocks are collected into sticky interrupt bits, and an active-low interrupt request goes to the host.

The SPI pins are oversampled by the block clock through synchronizers, so SCLK must stay well below the block clock. A transfer is one 16-bit frame sent MSB first: a direction bit, five pad bits, two address bits and one data byte. A read returns the register value captured when the address bits arrive. The side effects of a frame take place when chip select rises: a write updates its register, and a status read clears the interrupt bits the host was shown.

Top module: `spirf_top`

## Requirements
- R1: A frame is exactly 16 rising SCLK edges while CS is low. Bit 15 is the direction (1 = write, 0 = read), bits 14:10 are ignored, bits 9:8 select the register and bits 7:0 are data, all MSB first. A frame with any other edge count has no effect. SDO is low whenever CS is high.
- R2: After reset all four registers read 0, IRQ is high and SDO is low.
- R3: The address selects the register: 00 status, 01 line config, 10 I/O config, 11 mode. Config writes take effect at CS rise. A read returns the value the register held when the address bits were received.
- R4: The status layout is: bit 7 wake-up, bit 6 auxiliary-output fault, bit 5 live input level, bit 4 live line level, bit 3 line fault, bit 2 low-rail undervoltage, bit 1 main-supply undervoltage, bit 0 overtemperature.
- R5: IRQ is low exactly while one of status bits 7, 6 or 3..0 is set. Bits 5 and 4 never affect IRQ.
- R6: A completed status read clears, at CS rise, only the interrupt bits it returned. An event that arrives after the address phase stays set. The level bits are never cleared.
- R7: The line fault and the auxiliary fault are level sources, so their bits set again right after a read while the fault persists. The low-rail, supply and overtemperature bits set once per rising edge of their input. The wake-up bit sets only while mode bit 6 is 1.
- R8: Mode bits 5..2 show the live auxiliary fault, line fault, supply-low and overtemperature inputs. Writes do not change them. Bits 6, 1 and 0 are writable.
- R9: Writing mode with bit 7 set clears both config registers and the writable mode bits, leaves mode bit 7 at 1 and clears the status register. While mode bit 7 is 1, no interrupt bit sets.
- R10: The low-rail interrupt sets whatever mode bit 1 holds. The undervoltage output is supply-low OR (low-rail AND mode bit 1).
- R11: A write to the status address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sdi | input | 1 | SPI data from host |
| spi_sdo | output | 1 | SPI data to host |
| wake_pulse | input | 1 | One-cycle wake-up detection pulse |
| aux_fault | input | 1 | Live auxiliary-output fault level |
| line_fault | input | 1 | Live line-driver fault level |
| rail_low | input | 1 | Low-voltage rail below threshold |
| supply_low | input | 1 | Main supply below threshold |
| overtemp | input | 1 | Die temperature warning level |
| in_lvl | input | 1 | Live auxiliary input logic level |
| line_low | input | 1 | Live line level, 1 when the line is low |
| irq_n | output | 1 | Interrupt request, active low |
| uv_o | output | 1 | Combined undervoltage indication |
| line_cfg | output | 8 | Line-driver configuration register |
| io_cfg | output | 8 | Auxiliary I/O configuration register |
| mode_reg | output | 8 | Mode register as read by the host |

## Verification
Each interrupt source is driven in isolation and then in combination with the others. A held fault level is set against a one-time edge, which shows which sources re-arm after a status read and which need a new rising edge. An event injected after the address phase of a status read tells a clear of only the returned bits apart from a blanket clear. The level bits are toggled with no fault present to show that IRQ ignores them. Frames that are too short, writes to the status address, mode writes carrying arbitrary fault-bit values, and the register-reset hold with events arriving during it each test one protection rule. A reference model compares IRQ, the undervoltage output and all configuration outputs on every clock.

// File: rtl/spirf_pkg.sv
package spirf_pkg;
   localparam int unsigned REG_W = 8;

   typedef enum logic [1:0] {
      RA_STATUS = 2'b00,
      RA_LINE   = 2'b01,
      RA_IO     = 2'b10,
      RA_MODE   = 2'b11
   } reg_addr_e;

   // status bit positions
   localparam int unsigned ST_WAKE   = 7;
   localparam int unsigned ST_AUXF   = 6;
   localparam int unsigned ST_INLVL  = 5;
   localparam int unsigned ST_LNLVL  = 4;
   localparam int unsigned ST_LINEF  = 3;
   localparam int unsigned ST_RAIL   = 2;
   localparam int unsigned ST_SUPPLY = 1;
   localparam int unsigned ST_OTEMP  = 0;

   // mode bit positions
   localparam int unsigned MD_RESET  = 7;
   localparam int unsigned MD_WAKEEN = 6;
   localparam int unsigned MD_UVEN   = 1;
   localparam int unsigned MD_RAILOFF = 0;

   localparam logic [REG_W-1:0] ST_INT_MASK = 8'hCF;
endpackage

// File: rtl/spirf_sync.sv
module spirf_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spirf_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d_i};
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/spirf_frame.sv
module spirf_frame #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned PAD_W       = 5,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_i,
   input  logic              cs_n_i,
   input  logic              sdi_i,
   output logic              sdo_o,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              wr_o,
   output logic              addr_vld_o,
   output logic [DATA_W-1:0] snap_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic              done_o
);
   localparam int unsigned HEAD_W  = 1 + PAD_W + ADDR_W;
   localparam int unsigned FRAME_W = HEAD_W + DATA_W;
   localparam int unsigned CNT_W   = $clog2(FRAME_W + 2);
   localparam int unsigned SH_W    = (HEAD_W > DATA_W) ? HEAD_W : DATA_W;
   localparam int unsigned IDX_W   = $clog2(DATA_W);

   logic sclk_s, cs_s, sdi_s;
   logic sclk_d, cs_d;

   spirf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk
      (.clk(clk), .rst_n(rst_n), .d_i(sclk_i), .q_o(sclk_s));
   spirf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs
      (.clk(clk), .rst_n(rst_n), .d_i(cs_n_i), .q_o(cs_s));
   spirf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi
      (.clk(clk), .rst_n(rst_n), .d_i(sdi_i), .q_o(sdi_s));

   logic              rise, cs_up;
   logic [SH_W-1:0]   shift, sh_next;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] shadow;
   logic [ADDR_W-1:0] hdr_addr;
   logic              hdr_wr;
   logic              vld_q, done_q, sdo_q;
   logic [IDX_W-1:0]  ridx;
   logic              in_data;

   assign rise    = sclk_s & ~sclk_d & ~cs_s;
   assign cs_up   = cs_s & ~cs_d;
   assign sh_next = {shift[SH_W-2:0], sdi_s};
   assign ridx    = IDX_W'(CNT_W'(FRAME_W - 1) - cnt);
   assign in_data = (cnt >= CNT_W'(HEAD_W)) && (cnt < CNT_W'(FRAME_W));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d   <= 1'b0;
         cs_d     <= 1'b1;
         shift    <= '0;
         cnt      <= '0;
         shadow   <= '0;
         hdr_addr <= '0;
         hdr_wr   <= 1'b0;
         vld_q    <= 1'b0;
         done_q   <= 1'b0;
         sdo_q    <= 1'b0;
      end else begin
         sclk_d <= sclk_s;
         cs_d   <= cs_s;
         vld_q  <= 1'b0;
         done_q <= cs_up && (cnt == CNT_W'(FRAME_W));
         if (cs_s) begin
            cnt <= '0;
         end else if (rise) begin
            shift <= sh_next;
            if (cnt != '1) cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(HEAD_W - 1)) begin
               hdr_addr <= sh_next[ADDR_W-1:0];
               hdr_wr   <= sh_next[HEAD_W-1];
               vld_q    <= 1'b1;
            end
         end
         if (vld_q) shadow <= rd_data_i;
         sdo_q <= (!cs_s && !hdr_wr && in_data) ? shadow[ridx] : 1'b0;
      end
   end

   assign sdo_o      = sdo_q;
   assign addr_o     = hdr_addr;
   assign wr_o       = hdr_wr;
   assign addr_vld_o = vld_q;
   assign snap_o     = shadow;
   assign wdata_o    = shift[DATA_W-1:0];
   assign done_o     = done_q;

   assert_sdo_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> !sdo_o);
   assert_done_after_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> cs_s);
endmodule

// File: rtl/spirf_cfg.sv
module spirf_cfg
   import spirf_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              aux_fault_i,
   input  logic              line_fault_i,
   input  logic              supply_low_i,
   input  logic              overtemp_i,
   output logic [DATA_W-1:0] line_cfg_o,
   output logic [DATA_W-1:0] io_cfg_o,
   output logic [DATA_W-1:0] mode_o,
   output logic              hold_o,
   output logic              wake_en_o,
   output logic              uv_en_o
);
   logic [DATA_W-1:0] line_q, io_q;
   logic              rst_bit, wake_en, uv_en, rail_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q   <= '0;
         io_q     <= '0;
         rst_bit  <= 1'b0;
         wake_en  <= 1'b0;
         uv_en    <= 1'b0;
         rail_off <= 1'b0;
      end else if (wr_en_i) begin
         unique case (reg_addr_e'(wr_addr_i))
            RA_LINE: line_q <= wr_data_i;
            RA_IO:   io_q   <= wr_data_i;
            RA_MODE: begin
               if (wr_data_i[MD_RESET]) begin
                  line_q   <= '0;
                  io_q     <= '0;
                  rst_bit  <= 1'b1;
                  wake_en  <= 1'b0;
                  uv_en    <= 1'b0;
                  rail_off <= 1'b0;
               end else begin
                  rst_bit  <= 1'b0;
                  wake_en  <= wr_data_i[MD_WAKEEN];
                  uv_en    <= wr_data_i[MD_UVEN];
                  rail_off <= wr_data_i[MD_RAILOFF];
               end
            end
            default: ;
         endcase
      end
   end

   assign line_cfg_o = line_q;
   assign io_cfg_o   = io_q;
   assign mode_o     = {rst_bit, wake_en, aux_fault_i, line_fault_i,
                        supply_low_i, overtemp_i, uv_en, rail_off};
   assign hold_o     = rst_bit;
   assign wake_en_o  = wake_en;
   assign uv_en_o    = uv_en;

   assert_status_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_addr_i == ADDR_W'(RA_STATUS)) |=>
         ($stable(line_q) && $stable(io_q) && $stable(rst_bit) && $stable(wake_en)));
   assert_reset_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_addr_i == ADDR_W'(RA_MODE) && wr_data_i[MD_RESET]) |=>
         (line_q == '0 && io_q == '0 && hold_o));
endmodule

// File: rtl/spirf_status.sv
module spirf_status
   import spirf_pkg::*;
#(
   parameter int unsigned DATA_W          = 8,
   parameter bit          CLEAR_SEEN_ONLY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold_i,
   input  logic              wake_pulse_i,
   input  logic              wake_en_i,
   input  logic              aux_fault_i,
   input  logic              line_fault_i,
   input  logic              rail_low_i,
   input  logic              supply_low_i,
   input  logic              overtemp_i,
   input  logic              clr_i,
   input  logic [DATA_W-1:0] clr_snap_i,
   output logic [DATA_W-1:0] int_o
);
   logic [DATA_W-1:0] int_q, set_v, clr_v;
   logic              rail_d, supply_d, otemp_d;

   if (CLEAR_SEEN_ONLY) begin : g_clr_seen
      assign clr_v = clr_i ? (clr_snap_i & ST_INT_MASK) : '0;
   end else begin : g_clr_all
      assign clr_v = clr_i ? ST_INT_MASK : '0;
   end

   always_comb begin
      set_v            = '0;
      set_v[ST_WAKE]   = wake_pulse_i & wake_en_i;
      set_v[ST_AUXF]   = aux_fault_i;
      set_v[ST_LINEF]  = line_fault_i;
      set_v[ST_RAIL]   = rail_low_i & ~rail_d;
      set_v[ST_SUPPLY] = supply_low_i & ~supply_d;
      set_v[ST_OTEMP]  = overtemp_i & ~otemp_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_q    <= '0;
         rail_d   <= 1'b0;
         supply_d <= 1'b0;
         otemp_d  <= 1'b0;
      end else begin
         rail_d   <= rail_low_i;
         supply_d <= supply_low_i;
         otemp_d  <= overtemp_i;
         if (hold_i) int_q <= '0;
         else        int_q <= (int_q & ~clr_v) | set_v;
      end
   end

   assign int_o = int_q;

   assert_fault_rearms_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (line_fault_i && !hold_i) |=> int_o[ST_LINEF]);
   assert_hold_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> (int_o == '0));
   assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !hold_i) |=> ((int_o & $past(int_o)) == $past(int_o)));
   assert_no_level_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clr_i) |=> (int_o[ST_INLVL] == 1'b0 && int_o[ST_LNLVL] == 1'b0));
endmodule

// File: rtl/spirf_top.sv
module spirf_top
   import spirf_pkg::*;
#(
   parameter int unsigned DATA_W          = 8,
   parameter int unsigned ADDR_W          = 2,
   parameter int unsigned PAD_W           = 5,
   parameter int unsigned SYNC_STAGES     = 2,
   parameter bit          CLEAR_SEEN_ONLY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sclk,
   input  logic              spi_cs_n,
   input  logic              spi_sdi,
   output logic              spi_sdo,
   input  logic              wake_pulse,
   input  logic              aux_fault,
   input  logic              line_fault,
   input  logic              rail_low,
   input  logic              supply_low,
   input  logic              overtemp,
   input  logic              in_lvl,
   input  logic              line_low,
   output logic              irq_n,
   output logic              uv_o,
   output logic [DATA_W-1:0] line_cfg,
   output logic [DATA_W-1:0] io_cfg,
   output logic [DATA_W-1:0] mode_reg
);
   if (DATA_W != REG_W) begin : g_bad_data_w
      $error("spirf_top: DATA_W must equal the fixed register width");
   end
   if (ADDR_W != 2) begin : g_bad_addr_w
      $error("spirf_top: four registers need a 2-bit address");
   end

   logic [DATA_W-1:0] rd_data, snap, wdata, int_bits, status_view;
   logic [ADDR_W-1:0] addr;
   logic              wr, addr_vld, done;
   logic              hold, wake_en, uv_en;
   logic              clr, wr_en;

   spirf_frame #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PAD_W(PAD_W), .SYNC_STAGES(SYNC_STAGES)
   ) u_frame (
      .clk(clk), .rst_n(rst_n),
      .sclk_i(spi_sclk), .cs_n_i(spi_cs_n), .sdi_i(spi_sdi), .sdo_o(spi_sdo),
      .rd_data_i(rd_data), .addr_o(addr), .wr_o(wr), .addr_vld_o(addr_vld),
      .snap_o(snap), .wdata_o(wdata), .done_o(done)
   );

   assign wr_en = done & wr;
   assign clr   = done & ~wr & (addr == ADDR_W'(RA_STATUS));

   spirf_cfg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .wr_en_i(wr_en), .wr_addr_i(addr), .wr_data_i(wdata),
      .aux_fault_i(aux_fault), .line_fault_i(line_fault),
      .supply_low_i(supply_low), .overtemp_i(overtemp),
      .line_cfg_o(line_cfg), .io_cfg_o(io_cfg), .mode_o(mode_reg),
      .hold_o(hold), .wake_en_o(wake_en), .uv_en_o(uv_en)
   );

   spirf_status #(.DATA_W(DATA_W), .CLEAR_SEEN_ONLY(CLEAR_SEEN_ONLY)) u_status (
      .clk(clk), .rst_n(rst_n), .hold_i(hold),
      .wake_pulse_i(wake_pulse), .wake_en_i(wake_en),
      .aux_fault_i(aux_fault), .line_fault_i(line_fault),
      .rail_low_i(rail_low), .supply_low_i(supply_low), .overtemp_i(overtemp),
      .clr_i(clr), .clr_snap_i(snap), .int_o(int_bits)
   );

   always_comb begin
      status_view            = int_bits;
      status_view[ST_INLVL]  = in_lvl;
      status_view[ST_LNLVL]  = line_low;
   end

   always_comb begin
      unique case (reg_addr_e'(addr))
         RA_STATUS: rd_data = status_view;
         RA_LINE:   rd_data = line_cfg;
         RA_IO:     rd_data = io_cfg;
         default:   rd_data = mode_reg;
      endcase
   end

   assign irq_n = ~|(int_bits & ST_INT_MASK);
   assign uv_o  = supply_low | (rail_low & uv_en);

   assert_rail_irq_ungated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rail_low) && !hold) |=> !irq_n);
endmodule

// File: tb/spirf_top_tb.sv
module spirf_top_tb;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 10;
   localparam int WD_LIMIT   = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
   logic sdo;
   logic wake_pulse = 0, aux_fault = 0, line_fault = 0, rail_low = 0;
   logic supply_low = 0, overtemp = 0, in_lvl = 0, line_low = 0;
   logic irq_n, uv_o;
   logic [7:0] line_cfg, io_cfg, mode_reg;

   int checks = 0;
   int fails  = 0;
   bit guard  = 1'b1;

   always #(CLK_PERIOD/2) clk = ~clk;

   spirf_top u_dut (
      .clk(clk), .rst_n(rst_n),
      .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_sdi(sdi), .spi_sdo(sdo),
      .wake_pulse(wake_pulse), .aux_fault(aux_fault), .line_fault(line_fault),
      .rail_low(rail_low), .supply_low(supply_low), .overtemp(overtemp),
      .in_lvl(in_lvl), .line_low(line_low),
      .irq_n(irq_n), .uv_o(uv_o),
      .line_cfg(line_cfg), .io_cfg(io_cfg), .mode_reg(mode_reg)
   );

   // ---------------- reference model ----------------
   logic [7:0] m_stat = 0, m_line = 0, m_io = 0, m_ctl = 0;
   logic       p_rail = 0, p_sup = 0, p_ot = 0;
   int         cmd_seq = 0, seen_seq = 0;
   bit         cmd_clr = 0, cmd_wr = 0;
   logic [7:0] cmd_mask = 0, cmd_data = 0;
   logic [1:0] cmd_addr = 0;

   always @(posedge clk) begin
      logic [7:0] setv;
      if (!rst_n) begin
         m_stat = 0; m_line = 0; m_io = 0; m_ctl = 0;
         p_rail = 0; p_sup = 0; p_ot = 0; seen_seq = cmd_seq;
      end else begin
         if (seen_seq != cmd_seq) begin
            seen_seq = cmd_seq;
            if (cmd_clr) m_stat = m_stat & ~(cmd_mask & 8'hCF);
            if (cmd_wr) begin
               if (cmd_addr == 2'd1) m_line = cmd_data;
               else if (cmd_addr == 2'd2) m_io = cmd_data;
               else if (cmd_addr == 2'd3) begin
                  if (cmd_data[7]) begin
                     m_line = 0; m_io = 0; m_ctl = 8'h80; m_stat = 0;
                  end else m_ctl = cmd_data & 8'h43;
               end
            end
         end
         setv = 0;
         setv[7] = wake_pulse & m_ctl[6];
         setv[6] = aux_fault;
         setv[3] = line_fault;
         setv[2] = rail_low & !p_rail;
         setv[1] = supply_low & !p_sup;
         setv[0] = overtemp & !p_ot;
         if (m_ctl[7]) m_stat = 0;
         else m_stat = m_stat | setv;
         p_rail = rail_low; p_sup = supply_low; p_ot = overtemp;
      end
   end

   function automatic logic [7:0] m_view();
      return (m_stat & 8'hCF) | {2'b00, in_lvl, line_low, 4'b0000};
   endfunction

   function automatic logic [7:0] m_mode();
      return {m_ctl[7], m_ctl[6], aux_fault, line_fault, supply_low, overtemp,
              m_ctl[1], m_ctl[0]};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !guard) begin
         chk(irq_n == ((m_stat & 8'hCF) == 0), "R5 irq_n", irq_n, (m_stat & 8'hCF) == 0);
         chk(line_cfg == m_line, "R3 line_cfg", line_cfg, m_line);
         chk(io_cfg == m_io, "R3 io_cfg", io_cfg, m_io);
         chk(mode_reg == m_mode(), "R8 mode_reg", mode_reg, m_mode());
         chk(uv_o == (supply_low | (rail_low & m_ctl[1])), "R10 uv_o", uv_o,
             supply_low | (rail_low & m_ctl[1]));
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic xfer(input bit wr, input logic [1:0] a, input logic [7:0] d,
                       input int nbits, input int inj, output logic [7:0] q,
                       output logic [7:0] snap);
      logic [15:0] f;
      f    = {wr, 5'b00000, a, d};
      q    = 0;
      snap = m_view();
      if (a == 2'd1) snap = m_line;
      else if (a == 2'd2) snap = m_io;
      else if (a == 2'd3) snap = m_mode();
      tick(1);
      cs_n = 0;
      tick(HALF);
      for (int i = 15; i > 15 - nbits; i--) begin
         sdi = f[i];
         tick(HALF);
         if (i < 8) q[i] = sdo;
         sclk = 1;
         if (16 - i == inj) supply_low = 1;
         tick(HALF);
         sclk = 0;
      end
      tick(HALF);
      cs_n = 1;
      sdi  = 0;
      guard = 1;
      tick(10);
      if (nbits == 16) begin
         cmd_clr  = !wr && a == 2'd0;
         cmd_mask = snap;
         cmd_wr   = wr;
         cmd_addr = a;
         cmd_data = d;
         cmd_seq++;
      end
      tick(3);
      guard = 0;
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
      logic [7:0] q, s;
      xfer(1'b1, a, d, 16, -1, q, s);
   endtask

   task automatic rd_reg(input logic [1:0] a, input string req, input int inj,
                         output logic [7:0] q);
      logic [7:0] s;
      xfer(1'b0, a, 8'h00, 16, inj, q, s);
      chk(q == s, req, q, s);
   endtask

   // watchdog
   initial begin
      repeat (WD_LIMIT) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] q, s;
      tick(5);
      rst_n = 1;
      tick(2);
      // R2: reset state
      chk(irq_n == 1'b1, "R2 irq_n after reset", irq_n, 1);
      chk(spi_sdo_low(), "R2 sdo idle", sdo, 0);
      chk(line_cfg == 0 && io_cfg == 0 && mode_reg == 0, "R2 cfg zero",
          {line_cfg, io_cfg, mode_reg}, 0);
      guard = 0;
      rd_reg(2'd0, "R2 status reads 0", -1, q);
      chk(q == 8'h00, "R2 status value", q, 0);

      // R3: config writes and reads
      wr_reg(2'd1, 8'hA5);
      wr_reg(2'd2, 8'h3C);
      rd_reg(2'd1, "R3 line read", -1, q);
      chk(q == 8'hA5, "R3 line value", q, 8'hA5);
      rd_reg(2'd2, "R3 io read", -1, q);
      chk(q == 8'h3C, "R3 io value", q, 8'h3C);

      // R1: short frame ignored
      xfer(1'b1, 2'd1, 8'hFF, 12, -1, q, s);
      chk(line_cfg == 8'hA5, "R1 short frame ignored", line_cfg, 8'hA5);
      chk(sdo == 1'b0, "R1 sdo low with CS high", sdo, 0);

      // R8: mode writable bits and live fault bits
      wr_reg(2'd3, 8'h7F);
      chk(mode_reg == 8'h43, "R8 mode writable", mode_reg, 8'h43);
      aux_fault = 1; overtemp = 1;
      tick(4);
      chk(mode_reg == 8'h67, "R8 fault bits live", mode_reg, 8'h67);
      wr_reg(2'd3, 8'h00);
      chk(mode_reg == 8'h24, "R8 write keeps fault bits", mode_reg, 8'h24);
      chk(irq_n == 1'b0, "R5 irq asserted", irq_n, 0);

      // R4 / R7: level vs edge sources
      rd_reg(2'd0, "R4 status layout", -1, q);
      chk(q == 8'h41, "R4 aux+otemp", q, 8'h41);
      rd_reg(2'd0, "R7 aux re-set, otemp edge gone", -1, q);
      chk(q == 8'h40, "R7 persisting fault", q, 8'h40);
      aux_fault = 0; overtemp = 0;
      tick(3);
      rd_reg(2'd0, "R6 bit kept until read", -1, q);
      chk(q == 8'h40, "R6 sticky", q, 8'h40);
      rd_reg(2'd0, "R6 cleared", -1, q);
      chk(q == 8'h00 && irq_n == 1'b1, "R6 clear deasserts irq", {q, 7'd0, irq_n}, 1);

      // R5: level bits
      in_lvl = 1; line_low = 1;
      tick(4);
      chk(irq_n == 1'b1, "R5 level bits no irq", irq_n, 1);
      rd_reg(2'd0, "R4 level bits", -1, q);
      chk(q == 8'h30, "R4 level value", q, 8'h30);
      rd_reg(2'd0, "R6 level bits not cleared", -1, q);
      chk(q == 8'h30, "R6 levels stay", q, 8'h30);
      in_lvl = 0; line_low = 0;
      tick(2);

      // R7: wake gated by enable
      wake_pulse = 1; tick(1); wake_pulse = 0; tick(3);
      chk(irq_n == 1'b1, "R7 wake ignored when disabled", irq_n, 1);
      wr_reg(2'd3, 8'h40);
      wake_pulse = 1; tick(1); wake_pulse = 0; tick(3);
      rd_reg(2'd0, "R7 wake read", -1, q);
      chk(q == 8'h80, "R7 wake bit", q, 8'h80);

      // R10: rail interrupt ungated, uv output gated
      rail_low = 1; tick(4);
      chk(uv_o == 1'b0, "R10 uv gated off", uv_o, 0);
      rd_reg(2'd0, "R10 rail interrupt", -1, q);
      chk(q == 8'h04, "R10 rail bit", q, 8'h04);
      wr_reg(2'd3, 8'h42);
      chk(uv_o == 1'b1, "R10 uv enabled", uv_o, 1);
      rail_low = 0;
      wr_reg(2'd3, 8'h00);

      // R6: event after address phase survives the clear
      rd_reg(2'd0, "R6 race read", 12, q);
      chk(q == 8'h00, "R6 race snapshot", q, 0);
      chk(irq_n == 1'b0, "R6 late event kept", irq_n, 0);
      rd_reg(2'd0, "R6 late event read", -1, q);
      chk(q == 8'h02, "R6 supply bit", q, 8'h02);
      supply_low = 0;
      tick(2);

      // R11: status write ignored
      wr_reg(2'd0, 8'hFF);
      chk(line_cfg == 8'hA5 && io_cfg == 8'h3C, "R11 status write ignored",
          {line_cfg, io_cfg}, 16'hA53C);

      // R9: register reset and hold
      line_fault = 1; tick(3);
      rd_reg(2'd0, "R7 line fault", -1, q);
      chk(q == 8'h08, "R7 line bit", q, 8'h08);
      wr_reg(2'd3, 8'h80);
      chk(line_cfg == 0 && io_cfg == 0, "R9 cfg cleared", {line_cfg, io_cfg}, 0);
      chk(mode_reg == 8'h90, "R9 mode value", mode_reg, 8'h90);
      chk(irq_n == 1'b1, "R9 irq released", irq_n, 1);
      overtemp = 1; tick(5);
      chk(irq_n == 1'b1, "R9 no interrupt while held", irq_n, 1);
      rd_reg(2'd0, "R9 status held clear", -1, q);
      chk(q == 8'h00, "R9 status zero", q, 0);
      wr_reg(2'd3, 8'h00);
      chk(irq_n == 1'b0, "R9 fault re-arms after release", irq_n, 0);
      rd_reg(2'd0, "R9 after release", -1, q);
      chk(q == 8'h08, "R9 line bit only", q, 8'h08);
      line_fault = 0; overtemp = 0;
      tick(5);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   function automatic bit spi_sdo_low();
      return sdo == 1'b0;
   endfunction
endmodule